// File: doc/BRIEF.md
# Write Completion Response Tracker

This block sits on the write-response side of a host memory port. Each time the issue logic sends a multi-line write burst, it tells the tracker the request tag and how many cache lines (1, 2 or 4) the burst covers. The tracker then watches the 28-bit response header. It counts completed lines against each tag and pulses a done indication, carrying that tag, once every line of the burst is acknowledged.

Completions arrive in two forms, and the same remaining-line counter reconciles both. In the packed form, one response acknowledges the whole burst and its line-number field carries the size. In the unpacked form, each line is acknowledged on its own, in any order. A fence completion produces its own pulse. Interrupt completions and unknown response kinds leave the tracker untouched. A response that cannot be matched to outstanding lines raises an error flag, and the flag stays set until reset. The response channel has no back-pressure, so the tracker accepts one response on every clock cycle.

Top module: `wcomp_tracker`

## Requirements
- R1: After reset, `done_vld`, `fence_done` and `err_flag` are 0 and every tag has zero lines outstanding, so a write response to any tag only raises `err_flag`.
- R2: When `iss_vld` is high, the counter of tag `iss_tag` is loaded with `iss_lines` (1, 2 or 4). An issue overrides a response that targets the same tag in the same cycle.
- R3: A write response (`rsp_hdr[19:16]` = 0) with format bit `rsp_hdr[23]` = 0 takes exactly one line off its tag. The line number in `rsp_hdr[21:20]` does not change the count, so per-line responses may arrive in any order.
- R4: A write response with `rsp_hdr[23]` = 1 takes off the burst size coded in `rsp_hdr[21:20]`: code 0 means 1 line, code 1 means 2 lines and code 3 means 4 lines.
- R5: On the clock edge where a response brings a tag's counter to zero, `done_vld` rises for exactly one cycle and `done_tag` carries that tag.
- R6: A write response whose tag has no lines outstanding, whose packed size exceeds the remaining count, or which uses packed size code 2 sets `err_flag`. The counter is not changed, and the flag stays high until reset.
- R7: A response with kind `rsp_hdr[19:16]` = 4 (fence) raises `fence_done` for one cycle on the next edge. It changes no counter and never sets `err_flag`.
- R8: A response with kind 6 (interrupt), or with any kind other than 0 and 4, has no effect on counters, `done_vld`, `fence_done` or `err_flag`.
- R9: The tag is taken from `rsp_hdr[3:0]`. Metadata bits `rsp_hdr[15:4]`, channel bits `rsp_hdr[27:26]` and the hit bit `rsp_hdr[24]` do not affect tracking.
- R10: A response accepted on every cycle back to back is counted in full, with no response lost.
- R11: An issue to one tag and a write response to a different tag in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Issue notification valid |
| iss_tag | input | 4 | Tag of the issued burst |
| iss_lines | input | 3 | Number of lines in the burst (1, 2 or 4) |
| rsp_vld | input | 1 | Response valid strobe |
| rsp_hdr | input | 28 | Response header |
| done_vld | output | 1 | One-cycle pulse: a tag's burst has fully completed |
| done_tag | output | 4 | Tag whose burst completed |
| fence_done | output | 1 | One-cycle pulse: a fence completed |
| err_flag | output | 1 | Sticky unmatched-response error |

## Verification
The bench sends per-line completions in scrambled line order. A design that used the line number as an index, instead of as a count of one, would end early or never finish. It mixes packed bursts of all three sizes with per-line ones. A wrong size decode shows up as a missing or premature done pulse, and a design that accepted reserved code 2 would miss the error. It also checks several cases where a design could act when it should not:
- a packed size larger than the remaining count must set the error and still let later per-line completions finish;
- fences and interrupts sent to tags with outstanding lines must not count down;
- high metadata, channel and hit bits must not change the tag;
- back-to-back responses, and an issue landing in the same cycle as a response to another tag, must drop nothing.

// File: rtl/wct_pkg.sv
package wct_pkg;

   localparam int HDR_BITS = 28;

   typedef enum logic [3:0] {
      KIND_WRITE = 4'h0,
      KIND_FENCE = 4'h4,
      KIND_IRQ   = 4'h6
   } rsp_kind_e;

   typedef struct packed {
      logic [1:0]  chan;
      logic        rsv_a;
      logic        hit;
      logic        packed_fmt;
      logic        rsv_b;
      logic [1:0]  line_code;
      logic [3:0]  kind;
      logic [15:0] meta;
   } rsp_hdr_t;

endpackage

// File: rtl/wct_rsp_decode.sv
module wct_rsp_decode
   import wct_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int CNT_W     = 3,
   parameter bit PACKED_EN = 1'b1
) (
   input  logic                 rsp_vld,
   input  logic [HDR_BITS-1:0]  rsp_hdr,
   output logic                 wr_vld,
   output logic                 fence_vld,
   output logic [TAG_W-1:0]     tag,
   output logic [CNT_W-1:0]     dec,
   output logic                 size_bad
);

   rsp_hdr_t h;
   assign h         = rsp_hdr_t'(rsp_hdr);
   assign wr_vld    = rsp_vld && (h.kind == KIND_WRITE);
   assign fence_vld = rsp_vld && (h.kind == KIND_FENCE);
   assign tag       = h.meta[TAG_W-1:0];

   if (PACKED_EN) begin : g_packed
      always_comb begin
         dec      = CNT_W'(1);
         size_bad = 1'b0;
         if (h.packed_fmt) begin
            unique case (h.line_code)
               2'd0:    dec = CNT_W'(1);
               2'd1:    dec = CNT_W'(2);
               2'd3:    dec = CNT_W'(4);
               default: size_bad = 1'b1;
            endcase
         end
      end
   end else begin : g_unpacked_only
      assign dec      = CNT_W'(1);
      assign size_bad = h.packed_fmt;
   end

endmodule

// File: rtl/wct_cnt_bank.sv
module wct_cnt_bank #(
   parameter int NTAG  = 16,
   parameter int TAG_W = 4,
   parameter int CNT_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic [TAG_W-1:0]        ld_tag,
   input  logic [CNT_W-1:0]        ld_val,
   input  logic                    sub_en,
   input  logic [TAG_W-1:0]        sub_tag,
   input  logic [CNT_W-1:0]        sub_val,
   output logic [NTAG*CNT_W-1:0]   cnt_flat
);

   for (genvar i = 0; i < NTAG; i++) begin : g_tag
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (ld_en && (ld_tag == TAG_W'(i)))
            cnt_q <= ld_val;
         else if (sub_en && (sub_tag == TAG_W'(i)))
            cnt_q <= cnt_q - sub_val;
      end
      assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q;
   end

endmodule

// File: rtl/wcomp_tracker.sv
module wcomp_tracker
   import wct_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int CNT_W     = 3,
   parameter int HDR_W     = 28,
   parameter bit PACKED_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_vld,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [CNT_W-1:0]  iss_lines,
   input  logic              rsp_vld,
   input  logic [HDR_W-1:0]  rsp_hdr,
   output logic              done_vld,
   output logic [TAG_W-1:0]  done_tag,
   output logic              fence_done,
   output logic              err_flag
);

   localparam int NTAG = 1 << TAG_W;

   if (CNT_W < 3) begin : g_bad_cnt
      $error("CNT_W must be at least 3 to hold a four-line burst");
   end
   if (HDR_W != HDR_BITS) begin : g_bad_hdr
      $error("HDR_W must match the response header layout");
   end
   if (TAG_W < 1 || TAG_W > 16) begin : g_bad_tag
      $error("TAG_W must lie within the metadata field");
   end

   logic              wr_vld, fence_vld, size_bad;
   logic [TAG_W-1:0]  r_tag;
   logic [CNT_W-1:0]  r_dec, cur;
   logic [NTAG*CNT_W-1:0] cnt_flat;
   logic              accept, reject, hits_zero;

   wct_rsp_decode #(.TAG_W(TAG_W), .CNT_W(CNT_W), .PACKED_EN(PACKED_EN)) u_dec (
      .rsp_vld   (rsp_vld),
      .rsp_hdr   (rsp_hdr),
      .wr_vld    (wr_vld),
      .fence_vld (fence_vld),
      .tag       (r_tag),
      .dec       (r_dec),
      .size_bad  (size_bad)
   );

   assign cur       = cnt_flat[r_tag*CNT_W +: CNT_W];
   assign accept    = wr_vld && !size_bad && (cur != '0) && (r_dec <= cur);
   assign reject    = wr_vld && !accept;
   assign hits_zero = accept && (cur == r_dec);

   wct_cnt_bank #(.NTAG(NTAG), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (iss_vld),
      .ld_tag   (iss_tag),
      .ld_val   (iss_lines),
      .sub_en   (accept),
      .sub_tag  (r_tag),
      .sub_val  (r_dec),
      .cnt_flat (cnt_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_vld   <= 1'b0;
         done_tag   <= '0;
         fence_done <= 1'b0;
         err_flag   <= 1'b0;
      end else begin
         done_vld   <= hits_zero;
         if (hits_zero) done_tag <= r_tag;
         fence_done <= fence_vld;
         err_flag   <= err_flag | reject;
      end
   end

endmodule

// File: rtl/wct_checker.sv
module wct_checker #(
   parameter int TAG_W = 4,
   parameter int CNT_W = 3,
   parameter int HDR_W = 28,
   parameter int NTAG  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   iss_vld,
   input logic [TAG_W-1:0]       iss_tag,
   input logic                   rsp_vld,
   input logic [HDR_W-1:0]       rsp_hdr,
   input logic                   done_vld,
   input logic [TAG_W-1:0]       done_tag,
   input logic                   fence_done,
   input logic                   err_flag,
   input logic [NTAG*CNT_W-1:0]  cnt_flat
);

   // R5: a done pulse follows a write response
   a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |-> ($past(rsp_vld) && ($past(rsp_hdr[19:16]) == 4'h0)));

   // R5: the finished tag reads zero unless an issue reloaded it
   a_r5_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && !($past(iss_vld) && ($past(iss_tag) == done_tag)))
         |-> (cnt_flat[done_tag*CNT_W +: CNT_W] == '0));

   // R7: fence in, fence pulse out
   a_r7_fence_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && (rsp_hdr[19:16] == 4'h4)) |=> fence_done);

   a_r7_fence_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> ($past(rsp_vld) && ($past(rsp_hdr[19:16]) == 4'h4)));

   // R6: error is sticky
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R8: interrupt response is silent
   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && (rsp_hdr[19:16] == 4'h6)) |=> (!done_vld && !fence_done
         && ($rose(err_flag) == 1'b0)));

endmodule

bind wcomp_tracker wct_checker #(
   .TAG_W(TAG_W), .CNT_W(CNT_W), .HDR_W(HDR_W), .NTAG(NTAG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_vld    (iss_vld),
   .iss_tag    (iss_tag),
   .rsp_vld    (rsp_vld),
   .rsp_hdr    (rsp_hdr),
   .done_vld   (done_vld),
   .done_tag   (done_tag),
   .fence_done (fence_done),
   .err_flag   (err_flag),
   .cnt_flat   (cnt_flat)
);

// File: tb/wcomp_tracker_tb.sv
module wcomp_tracker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_vld = 1'b0;
   logic [3:0]  iss_tag = '0;
   logic [2:0]  iss_lines = '0;
   logic        rsp_vld = 1'b0;
   logic [27:0] rsp_hdr = '0;
   logic        done_vld, fence_done, err_flag;
   logic [3:0]  done_tag;

   always #4 clk = ~clk;

   wcomp_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_tag(iss_tag),
      .iss_lines(iss_lines), .rsp_vld(rsp_vld), .rsp_hdr(rsp_hdr),
      .done_vld(done_vld), .done_tag(done_tag), .fence_done(fence_done),
      .err_flag(err_flag)
   );

   typedef struct {
      bit    done;
      int    tag;
      bit    fence;
      bit    err;
      string req;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    fails  = 0;
   int    m_cnt[16];
   bit    m_err;
   bit    in_rst = 1'b1;

   // scoreboard monitor
   always @(posedge clk) begin
      #2;
      if (!in_rst && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (done_vld !== e.done || fence_done !== e.fence || err_flag !== e.err
             || (e.done && done_tag !== 4'(e.tag))) begin
            fails++;
            $display("FAIL %s: done=%0b tag=%0d fence=%0b err=%0b expected done=%0b tag=%0d fence=%0b err=%0b",
                     e.req, done_vld, done_tag, fence_done, err_flag,
                     e.done, e.tag, e.fence, e.err);
         end
      end
   end

   task automatic do_reset(input string req);
      in_rst = 1'b1;
      sb_q.delete();
      rst_n = 1'b0;
      iss_vld = 1'b0;
      rsp_vld = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (done_vld !== 1'b0 || fence_done !== 1'b0 || err_flag !== 1'b0) begin
         fails++;
         $display("FAIL %s: done=%0b fence=%0b err=%0b expected 0 0 0",
                  req, done_vld, fence_done, err_flag);
      end
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_err = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      in_rst = 1'b0;
   endtask

   // one cycle of stimulus; expected outputs go into the scoreboard
   task automatic step(input bit iv, input int itag, input int ilines,
                       input bit rv, input int kind, input bit fmt,
                       input int code, input int meta, input bit noise,
                       input string req);
      exp_t e;
      int   t, dec;
      bit   bad;
      e.done = 0; e.tag = 0; e.fence = 0; e.req = req;
      t = meta & 15;
      if (rv && kind == 0) begin
         bad = 0;
         dec = 1;
         if (fmt) begin
            case (code)
               0: dec = 1;
               1: dec = 2;
               3: dec = 4;
               default: bad = 1;
            endcase
         end
         if (bad || m_cnt[t] == 0 || dec > m_cnt[t]) m_err = 1'b1;
         else begin
            m_cnt[t] -= dec;
            if (m_cnt[t] == 0) begin e.done = 1; e.tag = t; end
         end
      end
      if (rv && kind == 4) e.fence = 1;
      if (iv) m_cnt[itag] = ilines;
      e.err = m_err;
      sb_q.push_back(e);
      iss_vld   = iv;
      iss_tag   = 4'(itag);
      iss_lines = 3'(ilines);
      rsp_vld   = rv;
      rsp_hdr   = {noise ? 2'b11 : 2'b00, 1'b0, noise, fmt, 1'b0, 2'(code),
                   4'(kind), 16'(meta)};
      @(negedge clk);
      iss_vld = 1'b0;
      rsp_vld = 1'b0;
   endtask

   task automatic idle(input string req);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
   endtask

   initial begin
      do_reset("R1 reset state");

      // R2 issue, R3 scrambled per-line order, R11 issue alongside response
      step(1, 2, 4, 0, 0, 0, 0, 0, 0, "R2 issue tag2");
      step(1, 5, 2, 1, 0, 0, 3, 2, 0, "R11 issue tag5 with rsp tag2");
      step(0, 0, 0, 1, 0, 0, 0, 2, 0, "R3 line0 tag2");
      step(0, 0, 0, 1, 0, 0, 2, 2, 0, "R3 line2 tag2");
      step(0, 0, 0, 1, 0, 0, 1, 2, 0, "R5 last line tag2");
      idle("R5 single pulse");
      // R4 packed 2, R9 noisy header bits
      step(0, 0, 0, 1, 0, 1, 1, 16'hAB5, 1, "R9 R4 packed2 tag5");
      // R4 packed 1 and 4
      step(1, 7, 1, 0, 0, 0, 0, 0, 0, "R2 issue tag7");
      step(1, 15, 4, 1, 0, 1, 0, 7, 0, "R4 packed1 tag7");
      step(0, 0, 0, 1, 0, 1, 3, 15, 0, "R4 packed4 tag15");
      // R7 fence, R8 interrupt and unknown kind
      step(1, 9, 2, 1, 4, 0, 0, 9, 0, "R7 fence");
      step(0, 0, 0, 1, 6, 0, 0, 9, 0, "R8 irq tag9");
      step(0, 0, 0, 1, 3, 1, 1, 9, 0, "R8 unknown kind tag9");
      step(0, 0, 0, 1, 0, 0, 0, 9, 0, "R8 tag9 still two");
      step(0, 0, 0, 1, 0, 0, 1, 9, 0, "R8 tag9 done");
      // R10 back to back
      step(1, 1, 2, 0, 0, 0, 0, 0, 0, "R2 issue tag1");
      step(1, 4, 1, 0, 0, 0, 0, 0, 0, "R2 issue tag4");
      step(0, 0, 0, 1, 0, 0, 1, 1, 0, "R10 rsp tag1");
      step(0, 0, 0, 1, 0, 0, 0, 4, 0, "R10 rsp tag4");
      step(0, 0, 0, 1, 0, 0, 0, 1, 0, "R10 rsp tag1 done");
      step(0, 0, 0, 1, 4, 0, 0, 0, 0, "R7 fence no error");
      idle("R7 fence single pulse");
      // R6 oversize packed: error, counter kept
      step(1, 6, 2, 0, 0, 0, 0, 0, 0, "R2 issue tag6");
      step(0, 0, 0, 1, 0, 1, 3, 6, 0, "R6 oversize packed");
      step(0, 0, 0, 1, 0, 0, 0, 6, 0, "R6 counter unchanged");
      step(0, 0, 0, 1, 0, 0, 1, 6, 0, "R6 tag6 done after error");
      idle("R6 sticky");

      do_reset("R1 reset clears error");
      step(1, 3, 4, 0, 0, 0, 0, 0, 0, "R2 issue tag3");
      step(0, 0, 0, 1, 0, 1, 2, 3, 0, "R6 reserved size code");
      step(0, 0, 0, 1, 0, 1, 3, 3, 0, "R6 tag3 unchanged by reserved");

      do_reset("R1 reset again");
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R1 zero outstanding after reset");
      idle("R6 sticky after unmatched");
      idle("R1 tail");
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule